// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides, frame by frame, whether an incoming frame is kept. It is fed the six destination address bytes as a byte stream, with a valid strobe for each byte and a start strobe that marks the first byte. While the bytes arrive it runs a bit-serial reflected CRC-32 over them and checks them against a programmed station address. Once the sixth byte has been taken it issues a one-cycle accept or reject.

Group (multicast) addresses are filtered through a 64-bit hash table held in four 16-bit words. Individual (unicast) addresses must match the station address exactly. The broadcast address always passes, and a promiscuous setting makes every frame pass. Software reaches the table, the configuration word and the station address through a small register port. Clearing the receive enable takes effect only once any address in progress has completed. Software polls the enable bit until it reads 0, and only then reloads the table.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, every register reads 0, the receiver is disabled and `decision_valid` is low.
- R2: The register map is 0..3 for the hash table words, 4 for configuration (bit 0 receive enable, bit 1 promiscuous) and 5..7 for the station address. Address byte 0 sits in bits 7:0 of register 5 and byte 1 in bits 15:8, and so on. A write takes effect at the clock edge, and `reg_rdata` always shows the register selected by `reg_addr`.
- R3: The hash index is formed as follows. The CRC starts at 0xFFFFFFFF. Each byte is taken in arrival order, least significant bit first. For each bit, that bit is XORed with CRC bit 0, the CRC is shifted right by one, and the constant 0xEDB88320 is XORed in when the XOR result was 1. After the six bytes, the index is CRC bits 31:26. Index bits 5:4 select the table word and bits 3:0 select the bit within it.
- R4: A group address has bit 0 of its first byte set. When the filter is not promiscuous and the address is not broadcast, a group address is accepted exactly when its hash table bit is 1.
- R5: With all four table words at 0xFFFF, every group address is accepted.
- R6: An individual address (bit 0 of byte 0 clear) is accepted only when all 48 bits equal the station address. The hash table has no effect on such addresses.
- R7: The address FF:FF:FF:FF:FF:FF is accepted whatever the table and station address hold.
- R8: With the promiscuous bit set, every frame is accepted.
- R9: A byte is taken on each clock edge where `addr_valid` is high, and idle cycles may fall between bytes. `decision_valid` is high for exactly one cycle: the cycle after the edge that takes the sixth byte.
- R10: A start strobe with `addr_valid` high, arriving part way through an address, discards the partial address and begins a new one. The decision then reflects only the new address.
- R11: If the enable bit is cleared while an address is in progress, it keeps reading 1 and that address still yields its decision. The bit reads 0 from the cycle after its last byte is taken. If it is cleared while idle, it reads 0 from the next cycle.
- R12: While the enable bit reads 0, or a disable is pending, start strobes are ignored and no decision is produced. Setting the enable bit again restores normal filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_byte | input | 8 | Destination address byte |
| addr_valid | input | 1 | `addr_byte` carries a byte this cycle |
| addr_start | input | 1 | Marks the first byte of an address (with `addr_valid`) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the selected register |
| decision_valid | output | 1 | One-cycle decision strobe |
| decision_accept | output | 1 | Frame accepted (meaningful with `decision_valid`) |

## Verification
The assertions take two things for granted about the inputs. First, the byte stream never delivers six bytes in fewer than six cycles. Second, every byte other than the first comes with `addr_start` low, so a start strobe always means a new address. The directed stimulus drives one byte per cycle with the start strobe on the first byte only. It inserts idle gaps and restarts only in the scenarios that exercise them, and it makes register writes on their own cycles. The one exception is the deliberate mid-address disable.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;

  typedef struct packed {
    logic promisc;
    logic enable;
  } cfg_t;

  // one data bit into a right-shifting (reflected) CRC-32
  function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
    logic fb;
    fb = c[0] ^ d;
    return (c >> 1) ^ (fb ? CRC_POLY_R : 32'h0);
  endfunction

  // one byte, least significant bit first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = crc_bit(r, b[i]);
    return r;
  endfunction

endpackage

// File: rtl/mhf_regs.sv
module mhf_regs #(
  parameter int TBL_WORDS  = 4,
  parameter int WORD_W     = 16,
  parameter int ADDR_BYTES = 6,
  parameter int REG_AW     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [REG_AW-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           rdata,
  input  logic                        busy,
  input  logic                        frame_end,
  output logic [TBL_WORDS*WORD_W-1:0] table_o,
  output logic [ADDR_BYTES*8-1:0]     station_o,
  output logic                        promisc_o,
  output logic                        en_o,
  output logic                        pend_o
);
  import mhf_pkg::*;

  localparam int STA_WORDS = (ADDR_BYTES * 8) / WORD_W;
  localparam int CFG_ADDR  = TBL_WORDS;
  localparam int STA_BASE  = TBL_WORDS + 1;

  logic [WORD_W-1:0] tbl [TBL_WORDS];
  logic [WORD_W-1:0] sta [STA_WORDS];
  cfg_t              cfg_q;
  logic              pend_q;
  logic              cfg_wr;

  assign cfg_wr = wr && (addr == REG_AW'(CFG_ADDR));

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n)                          tbl[w] <= '0;
      else if (wr && addr == REG_AW'(w))   tbl[w] <= wdata;
    end
    assign table_o[w*WORD_W +: WORD_W] = tbl[w];
  end

  for (genvar s = 0; s < STA_WORDS; s++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rst_n)                                   sta[s] <= '0;
      else if (wr && addr == REG_AW'(STA_BASE + s)) sta[s] <= wdata;
    end
    assign station_o[s*WORD_W +: WORD_W] = sta[s];
  end

  // enable with deferred clear: a clear during an address waits for its end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q.promisc <= wdata[1];
      if (wdata[0]) begin
        cfg_q.enable <= 1'b1;
        pend_q       <= 1'b0;
      end else if (cfg_q.enable && busy && !frame_end) begin
        pend_q <= 1'b1;
      end else begin
        cfg_q.enable <= 1'b0;
        pend_q       <= 1'b0;
      end
    end else if (pend_q && (!busy || frame_end)) begin
      cfg_q.enable <= 1'b0;
      pend_q       <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < TBL_WORDS; i++)
      if (addr == REG_AW'(i)) rdata = tbl[i];
    if (addr == REG_AW'(CFG_ADDR)) rdata = WORD_W'({cfg_q.promisc, cfg_q.enable});
    for (int i = 0; i < STA_WORDS; i++)
      if (addr == REG_AW'(STA_BASE + i)) rdata = sta[i];
  end

  assign promisc_o = cfg_q.promisc;
  assign en_o      = cfg_q.enable;
  assign pend_o    = pend_q;

endmodule

// File: rtl/mhf_seq.sv
module mhf_seq #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = $clog2(ADDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_valid,
  input  logic             addr_start,
  input  logic             rx_on,
  output logic             take_first,
  output logic             take_more,
  output logic             last_take,
  output logic             abort,
  output logic             busy,
  output logic [CNT_W-1:0] byte_idx
);

  logic [CNT_W-1:0] cnt_q;

  assign busy       = (cnt_q != '0);
  assign take_first = addr_valid && addr_start && rx_on;
  assign abort      = addr_valid && addr_start && !rx_on && busy;
  assign take_more  = addr_valid && !addr_start && busy;
  assign last_take  = take_more && (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign byte_idx   = take_first ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (take_first)        cnt_q <= CNT_W'(1);
    else if (abort || last_take) cnt_q <= '0;
    else if (take_more)         cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/mhf_track.sv
module mhf_track #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = $clog2(ADDR_BYTES),
  parameter int HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_first,
  input  logic                    take_more,
  input  logic [7:0]              byte_in,
  input  logic [CNT_W-1:0]        byte_idx,
  input  logic [ADDR_BYTES*8-1:0] station,
  output logic [HASH_W-1:0]       hash_idx,
  output logic                    group_cur,
  output logic                    bcast_next,
  output logic                    match_next
);
  import mhf_pkg::*;

  logic [31:0] crc_q, crc_base, crc_next;
  logic        group_q, bcast_q, match_q;
  logic        bcast_base, match_base;
  logic [7:0]  sta_byte;
  logic        take;

  assign take = take_first || take_more;

  always_comb begin
    sta_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (byte_idx == CNT_W'(i)) sta_byte = station[i*8 +: 8];
  end

  assign crc_base   = take_first ? CRC_SEED : crc_q;
  assign bcast_base = take_first ? 1'b1 : bcast_q;
  assign match_base = take_first ? 1'b1 : match_q;

  assign crc_next   = crc_byte(crc_base, byte_in);
  assign bcast_next = bcast_base && (byte_in == 8'hFF);
  assign match_next = match_base && (byte_in == sta_byte);
  assign group_cur  = take_first ? byte_in[0] : group_q;
  assign hash_idx   = crc_next[31 -: HASH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= CRC_SEED;
      group_q <= 1'b0;
      bcast_q <= 1'b0;
      match_q <= 1'b0;
    end else if (take) begin
      crc_q   <= crc_next;
      group_q <= group_cur;
      bcast_q <= bcast_next;
      match_q <= match_next;
    end
  end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int TBL_WORDS  = 4,
  parameter int WORD_W     = 16,
  localparam int REG_AW    = $clog2(TBL_WORDS + 1 + (ADDR_BYTES * 8) / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr_byte,
  input  logic              addr_valid,
  input  logic              addr_start,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              decision_valid,
  output logic              decision_accept
);

  localparam int HASH_W = $clog2(TBL_WORDS * WORD_W);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WSEL_W = HASH_W - BIT_W;
  localparam int CNT_W  = $clog2(ADDR_BYTES);

  // named internal events (observed by the bound checker)
  logic                        take_first_w, take_more_w, last_take_w, abort_w, busy_w;
  logic                        promisc_w, en_w, pend_w, rx_on_w;
  logic [CNT_W-1:0]            byte_idx_w;
  logic [TBL_WORDS*WORD_W-1:0] table_w;
  logic [ADDR_BYTES*8-1:0]     station_w;
  logic [HASH_W-1:0]           hash_idx_w;
  logic                        group_w, bcast_w, match_w;
  logic [WSEL_W-1:0]           wsel;
  logic [BIT_W-1:0]            bsel;
  logic [WORD_W-1:0]           word_sel;
  logic                        tbl_hit, accept_now;
  logic                        dv_q, acc_q;

  assign rx_on_w = en_w && !pend_w;

  mhf_regs #(
    .TBL_WORDS(TBL_WORDS), .WORD_W(WORD_W), .ADDR_BYTES(ADDR_BYTES), .REG_AW(REG_AW)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy_w), .frame_end(last_take_w || abort_w),
    .table_o(table_w), .station_o(station_w), .promisc_o(promisc_w),
    .en_o(en_w), .pend_o(pend_w)
  );

  mhf_seq #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
    .rx_on(rx_on_w), .take_first(take_first_w), .take_more(take_more_w),
    .last_take(last_take_w), .abort(abort_w), .busy(busy_w), .byte_idx(byte_idx_w)
  );

  mhf_track #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .HASH_W(HASH_W)) track_i (
    .clk(clk), .rst_n(rst_n), .take_first(take_first_w), .take_more(take_more_w),
    .byte_in(addr_byte), .byte_idx(byte_idx_w), .station(station_w),
    .hash_idx(hash_idx_w), .group_cur(group_w), .bcast_next(bcast_w),
    .match_next(match_w)
  );

  // upper index bits pick the word, lower bits the bit inside it
  assign wsel = hash_idx_w[HASH_W-1:BIT_W];
  assign bsel = hash_idx_w[BIT_W-1:0];

  always_comb begin
    word_sel = '0;
    for (int w = 0; w < TBL_WORDS; w++)
      if (wsel == WSEL_W'(w)) word_sel = table_w[w*WORD_W +: WORD_W];
  end

  assign tbl_hit    = word_sel[bsel];
  assign accept_now = promisc_w || bcast_w || (group_w ? tbl_hit : match_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      dv_q  <= last_take_w;
      acc_q <= last_take_w && accept_now;
    end
  end

  assign decision_valid  = dv_q;
  assign decision_accept = acc_q;

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic clk,
  input logic rst_n,
  input logic decision_valid,
  input logic decision_accept,
  input logic last_take,
  input logic promisc,
  input logic en,
  input logic pend,
  input logic busy
);

  a_r9_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> decision_valid);

  a_r9_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> $past(last_take));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);

  a_r8_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && $past(promisc)) |-> decision_accept);

  a_r11_pending_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);

  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> !decision_valid);

endmodule

bind mcast_hash_filter mhf_checker chk_i (
  .clk(clk), .rst_n(rst_n), .decision_valid(decision_valid),
  .decision_accept(decision_accept), .last_take(last_take_w),
  .promisc(promisc_w), .en(en_w), .pend(pend_w), .busy(busy_w)
);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic        addr_valid = 1'b0, addr_start = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        decision_valid, decision_accept;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .addr_byte(addr_byte), .addr_valid(addr_valid),
    .addr_start(addr_start), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .decision_valid(decision_valid), .decision_accept(decision_accept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference: walk the 48 address bits as one vector, byte 0 in bits 7:0
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (c[0] != a[k]) c = {1'b0, c[31:1]} ^ 32'hEDB8_8320;
      else              c = {1'b0, c[31:1]};
    end
    return c[31:26];
  endfunction

  function automatic logic [47:0] mac(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_table(input logic [15:0] w0, w1, w2, w3);
    wr(3'd0, w0); wr(3'd1, w1); wr(3'd2, w2); wr(3'd3, w3);
  endtask

  // drives one address; gap inserts an idle cycle after byte 2
  task automatic send(input logic [47:0] a, input bit gap,
                      output logic v, output logic acc, output logic v_after);
    @(negedge clk);
    addr_start = 1'b1; addr_valid = 1'b1; addr_byte = a[7:0];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      addr_start = 1'b0;
      if (gap && i == 3) begin
        addr_valid = 1'b0;
        #1 chk("R9 no decision during gap", decision_valid, 1'b0);
        @(negedge clk);
        addr_valid = 1'b1;
      end
      addr_byte = a[i*8 +: 8];
    end
    @(negedge clk);
    addr_valid = 1'b0;
    v = decision_valid; acc = decision_accept;
    @(negedge clk);
    v_after = decision_valid;
  endtask

  task automatic expect_frame(input string req, input logic [47:0] a, input bit gap,
                              input logic exp_acc);
    logic v, acc, v2;
    send(a, gap, v, acc, v2);
    chk({req, " valid"}, v, 1'b1);
    chk({req, " accept"}, acc, exp_acc);
    chk("R9 single-cycle valid", v2, 1'b0);
  endtask

  localparam logic [47:0] MC_A   = {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
  localparam logic [47:0] MC_B   = {8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h33};
  localparam logic [47:0] STA    = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  localparam logic [47:0] STA_X  = {8'h56, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  localparam logic [47:0] BCAST  = 48'hFFFF_FFFF_FFFF;

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 register reset value", d, 16'h0);
    end
    chk("R1 no decision after reset", decision_valid, 1'b0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(3'd2, 16'hA5C3);
    rd(3'd2, d); chk("R2 table word readback", d, 16'hA5C3);
    wr(3'd4, 16'h0003);
    rd(3'd4, d); chk("R2 config readback", d, 16'h0003);
    wr(3'd4, 16'h0001);
    wr(3'd5, {STA[15:8], STA[7:0]});
    wr(3'd6, {STA[31:24], STA[23:16]});
    wr(3'd7, {STA[47:40], STA[39:32]});
    rd(3'd6, d); chk("R2 station readback", d, 16'h3322);
  endtask

  task automatic t_hash();
    logic [5:0]  h;
    logic [15:0] w [4];
    h = ref_hash(MC_A);
    for (int i = 0; i < 4; i++) w[i] = 16'h0;
    w[h[5:4]] = 16'h1 << h[3:0];
    set_table(w[0], w[1], w[2], w[3]);
    expect_frame("R3 R4 hash hit", MC_A, 0, 1'b1);
    for (int i = 0; i < 4; i++) w[i] = 16'hFFFF;
    w[h[5:4]] = ~(16'h1 << h[3:0]);
    set_table(w[0], w[1], w[2], w[3]);
    expect_frame("R3 R4 hash miss", MC_A, 0, 1'b0);
    h = ref_hash(MC_B);
    for (int i = 0; i < 4; i++) w[i] = 16'h0;
    w[h[5:4]] = 16'h1 << h[3:0];
    set_table(w[0], w[1], w[2], w[3]);
    expect_frame("R3 R9 hash hit with idle gap", MC_B, 1, 1'b1);
  endtask

  task automatic t_allmulti();
    set_table(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    expect_frame("R5 full table group A", MC_A, 0, 1'b1);
    expect_frame("R5 full table group B", MC_B, 0, 1'b1);
    expect_frame("R6 full table unicast mismatch", STA_X, 0, 1'b0);
  endtask

  task automatic t_unicast();
    set_table(16'h0, 16'h0, 16'h0, 16'h0);
    expect_frame("R6 station match", STA, 0, 1'b1);
    expect_frame("R6 station mismatch", STA_X, 0, 1'b0);
    expect_frame("R7 broadcast empty table", BCAST, 0, 1'b1);
    expect_frame("R4 group miss empty table", MC_A, 0, 1'b0);
  endtask

  task automatic t_promisc();
    wr(3'd4, 16'h0003);
    expect_frame("R8 promisc unicast mismatch", STA_X, 0, 1'b1);
    expect_frame("R8 promisc group empty table", MC_A, 0, 1'b1);
    wr(3'd4, 16'h0001);
    expect_frame("R8 promisc off again", STA_X, 0, 1'b0);
  endtask

  task automatic t_restart();
    @(negedge clk);
    addr_start = 1'b1; addr_valid = 1'b1; addr_byte = STA_X[7:0];
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      addr_start = 1'b0; addr_byte = STA_X[i*8 +: 8];
    end
    #1 chk("R10 no decision from partial", decision_valid, 1'b0);
    expect_frame("R10 restarted address decides", STA, 0, 1'b1);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    logic v, acc, v2;
    @(negedge clk);
    addr_start = 1'b1; addr_valid = 1'b1; addr_byte = STA[7:0];
    @(negedge clk); addr_start = 1'b0; addr_byte = STA[15:8];
    @(negedge clk); addr_byte = STA[23:16];
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0000;
    @(negedge clk); addr_byte = STA[31:24]; reg_wr = 1'b0;
    #1 chk("R11 enable still reads 1 mid-address", reg_rdata[0], 1'b1);
    @(negedge clk); addr_byte = STA[39:32];
    #1 chk("R11 enable still 1 near end", reg_rdata[0], 1'b1);
    @(negedge clk); addr_byte = STA[47:40];
    @(negedge clk); addr_valid = 1'b0;
    chk("R11 pending address completes", decision_valid, 1'b1);
    chk("R11 pending address accepted", decision_accept, 1'b1);
    #1 chk("R11 enable reads 0 after address", reg_rdata[0], 1'b0);
    send(STA, 0, v, acc, v2);
    chk("R12 disabled ignores address", v, 1'b0);
    chk("R12 disabled stays quiet", v2, 1'b0);
    wr(3'd4, 16'h0001);
    expect_frame("R12 re-enabled filters", STA, 0, 1'b1);
    wr(3'd4, 16'h0000);
    rd(3'd4, d); chk("R11 idle clear reads 0", d[0], 1'b0);
    send(BCAST, 0, v, acc, v2);
    chk("R12 idle-disabled ignores broadcast", v, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_hash();
    t_allmulti();
    t_unicast();
    t_promisc();
    t_restart();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule